// File: doc/BRIEF.md
# Prescaled Watchdog Underflow Timer

This block catches a program that has stopped servicing its supervisor. A free-running prescaler turns the internal clock into a slower tick stream, and each tick decrements a down-counter that is 15 bits wide by default. If software does not restart the count in time, the counter passes below zero. It then raises a one-cycle interrupt request, reloads its maximum value and keeps counting.

Software talks to the block over a byte-wide register write bus. A write to the control address (0x0F) sets the prescaler ratio through data bit 7. A write of any data to the restart address (0x0E) reloads the counter. A read-back byte carries the ratio bit together with the counter's most significant bits, so that software can see how much time is left.

The restart does not clear the prescaler. The first period after a restart can therefore be up to one prescaler interval shorter than a full period.

Top module: `wdg_timer`

## Requirements
- R1: While reset is active and after it is released, the counter holds its all-ones value (0x7FFF at the default width), the ratio bit reads 0 and `wdg_irq` is 0.
- R2: With the ratio bit at 0, the prescaler issues one tick every 16 clocks. The first tick comes at the 16th rising edge after reset is released, and the counter drops by exactly one on each tick.
- R3: With the ratio bit at 1, the prescaler issues one tick every 128 clocks, aligned to multiples of 128 edges since reset.
- R4: A write to address 0x0F stores data bit 7 as the ratio bit (0 selects divide-by-16, 1 selects divide-by-128) and ignores bits 6..0. `ctrl_rdata` bit 7 is the ratio bit, and bits 6..0 are the counter's seven most significant bits.
- R5: A tick that finds the counter at zero reloads all ones. `wdg_irq` is then high in the following cycle, which gives a full period of 2^CNT_W ticks.
- R6: A write to address 0x0E reloads the all-ones value whatever the data is, and it takes priority over a tick in the same cycle.
- R7: A restart leaves the prescaler phase untouched. The next decrement after a restart comes at the next prescaler tick, not one full interval later.
- R8: A write to any address other than 0x0E and 0x0F changes neither the counter nor the ratio bit.
- R9: `wdg_irq` is a single-cycle pulse and is low in the cycle after it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe of the register bus |
| bus_addr | input | 8 | Byte address of the write |
| bus_wdata | input | 8 | Write data |
| wdg_irq | output | 1 | Underflow interrupt request, one-cycle pulse |
| ctrl_rdata | output | 8 | Ratio bit in bit 7, counter's top bits in bits 6..0 |

## Verification
The timer is run under three patterns: undisturbed from reset at divide-by-16, undisturbed at divide-by-128, and restarted at a point that lies halfway between prescaler ticks. The two undisturbed runs separate the two ratios by the exact cycle of each interrupt pulse and of each step in the read-back. The restart run separates a prescaler that keeps its phase from one that is cleared, because the two predict decrements eight cycles apart. Writes that carry stray bits, and writes to unrelated addresses, are placed between read-back samples so that any effect they have would show up.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   typedef enum logic {
      DIV_FINE   = 1'b0,
      DIV_COARSE = 1'b1
   } div_sel_e;

   localparam int unsigned BUS_W        = 8;
   localparam int unsigned DEF_CNT_W    = 15;
   localparam int unsigned DEF_FINE_LG  = 4;
   localparam int unsigned DEF_COARSE_LG = 7;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
   import wdg_pkg::*;
#(
   parameter int unsigned FINE_LG   = DEF_FINE_LG,
   parameter int unsigned COARSE_LG = DEF_COARSE_LG
) (
   input  logic     clk,
   input  logic     rst_n,
   input  div_sel_e sel,
   output logic     tick
);
   if (FINE_LG < 1 || COARSE_LG <= FINE_LG) begin : g_bad_ratio
      $error("wdg_prescaler: need 1 <= FINE_LG < COARSE_LG");
   end

   logic [COARSE_LG-1:0] phase;
   logic                 fine_hit;
   logic                 coarse_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= '0;
      else        phase <= phase + 1'b1;
   end

   assign fine_hit   = &phase[FINE_LG-1:0];
   assign coarse_hit = &phase;
   assign tick       = (sel == DIV_COARSE) ? coarse_hit : fine_hit;

   assert_tick_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   assert_coarse_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sel == DIV_COARSE) |-> (phase == '1));
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int unsigned  ADDR_W    = BUS_W,
   parameter int unsigned  DATA_W    = BUS_W,
   parameter logic [7:0]   CTRL_ADDR = 8'h0F,
   parameter logic [7:0]   KICK_ADDR = 8'h0E,
   parameter int unsigned  SEL_BIT   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output div_sel_e          sel,
   output logic              kick
);
   if (SEL_BIT >= DATA_W) begin : g_bad_bit
      $error("wdg_regs: SEL_BIT outside data word");
   end
   if (CTRL_ADDR == KICK_ADDR) begin : g_bad_map
      $error("wdg_regs: control and restart addresses collide");
   end

   logic ctrl_hit;
   logic unused_wdata_bits;

   assign ctrl_hit = we && (addr == ADDR_W'(CTRL_ADDR));
   assign kick     = we && (addr == ADDR_W'(KICK_ADDR));
   assign unused_wdata_bits = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n)        sel <= DIV_FINE;
      else if (ctrl_hit) sel <= div_sel_e'(wdata[SEL_BIT]);
   end

   assert_sel_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_hit |=> (sel == div_sel_e'($past(wdata[SEL_BIT]))));
   assert_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_hit |=> $stable(sel));
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int unsigned CNT_W = wdg_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             kick,
   output logic [CNT_W-1:0] cnt,
   output logic             irq
);
   localparam logic [CNT_W-1:0] RELOAD = '1;
   localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_width
      $error("wdg_counter: CNT_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= RELOAD;
         irq <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (kick) begin
            cnt <= RELOAD;
         end else if (tick) begin
            if (cnt == '0) begin
               cnt <= RELOAD;
               irq <= 1'b1;
            end else begin
               cnt <= cnt - ONE;
            end
         end
      end
   end

   assert_kick_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (cnt == RELOAD && !irq));
   assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !kick && cnt != '0) |=> (cnt == $past(cnt) - ONE));
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !kick) |=> $stable(cnt));
   assert_irq_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cnt == RELOAD));
   assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
   import wdg_pkg::*;
#(
   parameter int unsigned CNT_W     = DEF_CNT_W,
   parameter int unsigned FINE_LG   = DEF_FINE_LG,
   parameter int unsigned COARSE_LG = DEF_COARSE_LG
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_we,
   input  logic [7:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic       wdg_irq,
   output logic [7:0] ctrl_rdata
);
   localparam int unsigned RB_W = BUS_W - 1;

   div_sel_e         sel;
   logic             kick;
   logic             tick;
   logic [CNT_W-1:0] cnt;
   logic [RB_W-1:0]  cnt_view;

   wdg_regs #(
      .ADDR_W(BUS_W), .DATA_W(BUS_W),
      .CTRL_ADDR(8'h0F), .KICK_ADDR(8'h0E), .SEL_BIT(7)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .sel(sel), .kick(kick)
   );

   wdg_prescaler #(.FINE_LG(FINE_LG), .COARSE_LG(COARSE_LG)) pre_i (
      .clk(clk), .rst_n(rst_n), .sel(sel), .tick(tick)
   );

   wdg_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick),
      .cnt(cnt), .irq(wdg_irq)
   );

   if (CNT_W >= RB_W) begin : g_view_top
      assign cnt_view = cnt[CNT_W-1 -: RB_W];
   end else begin : g_view_pad
      assign cnt_view = {{(RB_W-CNT_W){1'b0}}, cnt};
   end

   assign ctrl_rdata = {sel, cnt_view};

   assert_rdata_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 8'h0F) |=> (ctrl_rdata[7] == $past(bus_wdata[7])));
   assert_irq_from_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdg_irq) |-> $past(tick && !kick));
endmodule

// File: tb/wdg_timer_tb_top.sv
module wdg_timer_tb_top;
   localparam int TB_CNT_W = 8;
   localparam int PERIOD16  = (1 << TB_CNT_W) * 16;
   localparam int PERIOD128 = (1 << TB_CNT_W) * 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic       wdg_irq;
   logic [7:0] ctrl_rdata;

   int cyc = 0;
   int n_tests = 0;
   int n_fail = 0;
   int exp_q[$];

   always #4 clk = ~clk;

   wdg_timer #(.CNT_W(TB_CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .wdg_irq(wdg_irq), .ctrl_rdata(ctrl_rdata)
   );

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", req, cyc, act, expv);
      end
   endtask

   // monitor: each interrupt pulse must match the next expected cycle (R5, R9)
   always @(negedge clk) begin
      if (rst_n && wdg_irq) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected irq", cyc, -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            check(cyc == e, "R5 irq cycle", cyc, e);
         end
      end
   end

   task automatic wait_cyc(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic do_reset();
      bus_we = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      exp_q.delete();
      repeat (3) @(negedge clk);
      check(wdg_irq == 1'b0, "R1 irq in reset", wdg_irq, 0);
      rst_n = 1'b1;
   endtask

   task automatic bus_write(input int edge_n, input logic [7:0] a, input logic [7:0] d);
      wait_cyc(edge_n - 1);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
   endtask

   task automatic sample(input int n, input logic [7:0] expv, input string req);
      wait_cyc(n);
      check(ctrl_rdata == expv, req, ctrl_rdata, expv);
   endtask

   task automatic drain(input int n, input string req);
      wait_cyc(n);
      check(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   initial begin
      // Phase A: divide-by-16 undisturbed
      do_reset();
      check(ctrl_rdata == 8'h7F, "R1 reset readback", ctrl_rdata, 8'h7F);
      exp_q.push_back(PERIOD16);
      exp_q.push_back(2 * PERIOD16);
      sample(15, 8'h7F, "R2 no tick before 16");
      sample(32, 8'h7E, "R2 two ticks");
      bus_write(40, 8'h20, 8'hFF);
      bus_write(41, 8'h0D, 8'hFF);
      bus_write(50, 8'h0F, 8'h7F);
      sample(64, 8'h7D, "R8 R4 stray writes ignored");
      sample(PERIOD16, 8'h7F, "R5 wrap to full");
      wait_cyc(PERIOD16 + 1);
      check(wdg_irq == 1'b0, "R9 pulse ends", wdg_irq, 0);
      drain(2 * PERIOD16 + 100, "R5 missing irq div16");

      // Phase B: restart between ticks keeps prescaler phase
      do_reset();
      bus_write(1000, 8'h0E, 8'h00);
      exp_q.push_back(2016 + (PERIOD16 - 16));
      bus_write(2008, 8'h0E, 8'hA5);
      sample(2008, 8'h7F, "R6 restart reload");
      sample(2032, 8'h7E, "R7 prescaler phase kept");
      drain(2016 + PERIOD16 + 100, "R7 missing irq after restart");

      // Phase C: divide-by-128
      do_reset();
      bus_write(5, 8'h0F, 8'h80);
      sample(5, 8'hFF, "R4 ratio bit readback");
      exp_q.push_back(PERIOD128);
      sample(200, 8'hFF, "R3 one slow tick");
      sample(256, 8'hFE, "R3 two slow ticks");
      drain(PERIOD128 + 100, "R3 missing irq div128");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d: actual hang expected finish", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule